// File: doc/BRIEF.md
# Paged program counter unit

This block holds the full program counter of a small microcontroller core. Its jump instructions carry only a short target field, 11 bits wide. The counter itself is 13 bits wide, so it addresses words 0x0000 to 0x1FFF. The missing upper bits come from a separate 5-bit page latch that software loads ahead of time. Software may also write the low byte of the counter directly. Such a write fills every bit above that byte from the latch, so a computed jump can land in any page.

The unit takes one of five actions on each clock: hold, step to the next word, jump on a GOTO or CALL, restore a saved address on a return, or load from a software low-byte write. During a CALL it presents the address to push onto the call stack. It also folds the counter down to the width of the program memory that is actually built. With the default 2K-word memory, all four 2K pages alias onto page 0. The call stack, the instruction decoder and the program memory sit outside this block.

Top module: `pgc_unit`

## Requirements
- R1: Reset (rst_n low) clears the counter to 0x0000 and clears the page latch. A GOTO issued right after reset therefore lands in page 0.
- R2: When inc_en is the only active command, the counter advances by one on each clock and wraps from 0x1FFF to 0x0000.
- R3: A GOTO or CALL (goto_en or call_en) loads the counter with {latch[4:3], jmp_tgt[10:0]}. All 13 bits change in the same clock.
- R4: A low-byte write (lo_wr_en) loads the counter with {latch[4:0], lo_wr_data[7:0]}.
- R5: A write to the page latch (lat_wr_en) on its own never changes the counter. The new latch value is used only at the next GOTO, CALL or low-byte write.
- R6: push_addr always equals the current counter plus one, modulo 0x2000.
- R7: A return (ret_en) loads all 13 bits from ret_val and leaves the page latch unchanged.
- R8: When several commands arrive in the same clock, the priority from highest to lowest is: low-byte write, return, GOTO/CALL, increment.
- R9: fetch_addr equals the counter with bits 12 and 11 forced to zero. This is the default 2K-word implemented memory (IMPL_W = 11).
- R10: If a low-byte write and a latch write arrive in the same clock, the low-byte write uses the latch value from before that clock. The new latch value applies from the next command on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Step to the next word |
| goto_en | input | 1 | Jump using the short target |
| call_en | input | 1 | Call using the short target |
| jmp_tgt | input | 11 | Target field of a GOTO or CALL |
| ret_en | input | 1 | Return: restore the counter |
| ret_val | input | 13 | Restore value for a return |
| lo_wr_en | input | 1 | Software write of the counter's low byte |
| lo_wr_data | input | 8 | Data for the low-byte write |
| lat_wr_en | input | 1 | Software write of the page latch |
| lat_wr_data | input | 5 | Data for the page latch write |
| pc | output | 13 | Current program counter |
| push_addr | output | 13 | Return address to push on a CALL |
| fetch_addr | output | 13 | Counter folded to the implemented memory |

## Verification
Every command changes pc at the first rising edge after it is applied, so its effect appears one cycle later. fetch_addr and push_addr are combinational from pc, so they are due in the same cycle as pc. The bench drives inputs on the falling edge. It advances its own counter and latch model on the rising edge and compares all three outputs at the next falling edge. Latch effects (R5, R10) are judged only through a later jump or low-byte write, because the latch has no output of its own.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
   typedef enum logic [2:0] {
      SRC_HOLD = 3'd0,
      SRC_INC  = 3'd1,
      SRC_JMP  = 3'd2,
      SRC_RET  = 3'd3,
      SRC_LO   = 3'd4
   } pc_src_e;
endpackage

// File: rtl/pgc_latch.sv
module pgc_latch #(
   parameter int LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LAT_W-1:0] wr_data,
   output logic [LAT_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
   end

   AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q)); // R7
endmodule

// File: rtl/pgc_next.sv
module pgc_next
   import pgc_pkg::*;
#(
   parameter int PC_W  = 13,
   parameter int JMP_W = 11,
   parameter int LO_W  = 8
) (
   input  logic [PC_W-1:0]      pc_q,
   input  logic [PC_W-LO_W-1:0] lat_q,
   input  logic                 inc_en,
   input  logic                 jmp_en,
   input  logic [JMP_W-1:0]     jmp_tgt,
   input  logic                 ret_en,
   input  logic [PC_W-1:0]      ret_val,
   input  logic                 lo_wr_en,
   input  logic [LO_W-1:0]      lo_wr_data,
   output pc_src_e              src,
   output logic [PC_W-1:0]      pc_d,
   output logic [PC_W-1:0]      pc_inc
);
   localparam int LAT_W = PC_W - LO_W;
   localparam int PG_W  = PC_W - JMP_W;

   assign pc_inc = pc_q + {{(PC_W-1){1'b0}}, 1'b1};

   always_comb begin
      if (lo_wr_en)    src = SRC_LO;
      else if (ret_en) src = SRC_RET;
      else if (jmp_en) src = SRC_JMP;
      else if (inc_en) src = SRC_INC;
      else             src = SRC_HOLD;
   end

   always_comb begin
      unique case (src)
         SRC_LO:   pc_d = {lat_q, lo_wr_data};
         SRC_RET:  pc_d = ret_val;
         SRC_JMP:  pc_d = {lat_q[LAT_W-1 -: PG_W], jmp_tgt};
         SRC_INC:  pc_d = pc_inc;
         default:  pc_d = pc_q;
      endcase
   end
endmodule

// File: rtl/pgc_fold.sv
module pgc_fold #(
   parameter int PC_W   = 13,
   parameter int IMPL_W = 11
) (
   input  logic [PC_W-1:0] pc_q,
   output logic [PC_W-1:0] fetch_addr
);
   generate
      if (IMPL_W < PC_W) begin : g_alias
         assign fetch_addr = {{(PC_W-IMPL_W){1'b0}}, pc_q[IMPL_W-1:0]};
      end else begin : g_full
         assign fetch_addr = pc_q;
      end
   endgenerate
endmodule

// File: rtl/pgc_unit.sv
module pgc_unit
   import pgc_pkg::*;
#(
   parameter int PC_W   = 13,
   parameter int JMP_W  = 11,
   parameter int LO_W   = 8,
   parameter int IMPL_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_en,
   input  logic              goto_en,
   input  logic              call_en,
   input  logic [JMP_W-1:0]  jmp_tgt,
   input  logic              ret_en,
   input  logic [PC_W-1:0]   ret_val,
   input  logic              lo_wr_en,
   input  logic [LO_W-1:0]   lo_wr_data,
   input  logic              lat_wr_en,
   input  logic [PC_W-LO_W-1:0] lat_wr_data,
   output logic [PC_W-1:0]   pc,
   output logic [PC_W-1:0]   push_addr,
   output logic [PC_W-1:0]   fetch_addr
);
   localparam int LAT_W = PC_W - LO_W;

   generate
      if (JMP_W <= LO_W || JMP_W >= PC_W) begin : g_bad_jmp
         $error("pgc_unit: JMP_W must lie between LO_W and PC_W");
      end
      if (IMPL_W < 1 || IMPL_W > PC_W) begin : g_bad_impl
         $error("pgc_unit: IMPL_W out of range");
      end
   endgenerate

   logic [PC_W-1:0]  pc_q, pc_d, pc_inc;
   logic [LAT_W-1:0] lat_q;
   pc_src_e          src;

   pgc_latch #(.LAT_W(LAT_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .wr_en(lat_wr_en),
      .wr_data(lat_wr_data), .q(lat_q));

   pgc_next #(.PC_W(PC_W), .JMP_W(JMP_W), .LO_W(LO_W)) u_next (
      .pc_q(pc_q), .lat_q(lat_q), .inc_en(inc_en),
      .jmp_en(goto_en | call_en), .jmp_tgt(jmp_tgt),
      .ret_en(ret_en), .ret_val(ret_val),
      .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
      .src(src), .pc_d(pc_d), .pc_inc(pc_inc));

   pgc_fold #(.PC_W(PC_W), .IMPL_W(IMPL_W)) u_fold (
      .pc_q(pc_q), .fetch_addr(fetch_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign pc        = pc_q;
   assign push_addr = pc_inc;

   AST_LAT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_en && !goto_en && !call_en && !ret_en && !lo_wr_en) |=> $stable(pc)); // R5
   AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !goto_en && !call_en && !ret_en && !lo_wr_en && (&pc)) |=> (pc == '0)); // R2
   AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && !lo_wr_en) |=> (pc == $past(ret_val))); // R7
   AST_JMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((goto_en || call_en) && !ret_en && !lo_wr_en) |=> (pc[JMP_W-1:0] == $past(jmp_tgt))); // R3
   AST_LO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr_en |=> (pc[LO_W-1:0] == $past(lo_wr_data))); // R4
   AST_FOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_addr[IMPL_W-1:0] == pc[IMPL_W-1:0]); // R9
endmodule

// File: tb/pgc_unit_tb.sv
module pgc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inc_en = 0, goto_en = 0, call_en = 0, ret_en = 0;
   logic        lo_wr_en = 0, lat_wr_en = 0;
   logic [10:0] jmp_tgt = '0;
   logic [12:0] ret_val = '0;
   logic [7:0]  lo_wr_data = '0;
   logic [4:0]  lat_wr_data = '0;
   logic [12:0] pc, push_addr, fetch_addr;

   int checks = 0;
   int failures = 0;
   logic [12:0] m_pc = '0;
   logic [4:0]  m_lat = '0;
   string       m_tag = "R1";

   always #2.5 clk = ~clk;

   pgc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .goto_en(goto_en),
      .call_en(call_en), .jmp_tgt(jmp_tgt), .ret_en(ret_en), .ret_val(ret_val),
      .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data), .lat_wr_en(lat_wr_en),
      .lat_wr_data(lat_wr_data), .pc(pc), .push_addr(push_addr),
      .fetch_addr(fetch_addr));

   function automatic logic [12:0] f_next(logic [12:0] p, logic [4:0] l);
      if (lo_wr_en)                 return {l, lo_wr_data};
      else if (ret_en)              return ret_val;
      else if (goto_en || call_en)  return {l[4:3], jmp_tgt};
      else if (inc_en)              return p + 13'd1;
      return p;
   endfunction

   function automatic string f_tag();
      int n = int'(lo_wr_en) + int'(ret_en) + int'(goto_en | call_en) + int'(inc_en);
      if (n > 1) return "R8";
      if (lo_wr_en && lat_wr_en) return "R10";
      if (lo_wr_en) return "R4";
      if (ret_en) return "R7";
      if (goto_en || call_en) return "R3";
      if (inc_en) return "R2";
      return "R5";
   endfunction

   task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk(m_tag, pc, m_pc);
      chk("R6", push_addr, m_pc + 13'd1);
      chk("R9", fetch_addr, {2'b00, m_pc[10:0]});
   endtask

   task automatic clear_cmds();
      inc_en = 0; goto_en = 0; call_en = 0; ret_en = 0;
      lo_wr_en = 0; lat_wr_en = 0;
   endtask

   // inputs already set after a negedge; run one edge and check
   task automatic step();
      logic [12:0] np;
      logic [4:0]  nl;
      np = f_next(m_pc, m_lat);
      nl = lat_wr_en ? lat_wr_data : m_lat;
      m_tag = f_tag();
      @(posedge clk);
      m_pc = np; m_lat = nl;
      @(negedge clk);
      check_outputs();
      clear_cmds();
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      // R1: reset state
      ret_val = 13'h1ABC; // prove nothing moves while in reset
      ret_en = 1;
      repeat (3) @(negedge clk);
      m_tag = "R1";
      check_outputs();
      clear_cmds();
      rst_n = 1;
      @(negedge clk);
      // R1: cleared latch puts GOTO in page 0
      goto_en = 1; jmp_tgt = 11'h5A5; step();
      chk("R1", pc, 13'h05A5);

      // R2: wrap 0x1FFF -> 0
      ret_en = 1; ret_val = 13'h1FFE; step();
      inc_en = 1; step();
      inc_en = 1; step();
      chk("R2", pc, 13'h0000);

      // R5: latch alone does not move pc, then takes effect at GOTO
      lat_wr_en = 1; lat_wr_data = 5'h1F; step();
      chk("R5", pc, 13'h0000);
      call_en = 1; jmp_tgt = 11'h123; step();
      chk("R5", pc, 13'h1923);

      // R4: low byte write pulls all latch bits
      lat_wr_en = 1; lat_wr_data = 5'h0A; step();
      lo_wr_en = 1; lo_wr_data = 8'h77; step();
      chk("R4", pc, 13'h0A77);

      // R10: simultaneous latch and low-byte write use old latch
      lo_wr_en = 1; lo_wr_data = 8'h01; lat_wr_en = 1; lat_wr_data = 5'h15; step();
      chk("R10", pc, 13'h0A01);
      lo_wr_en = 1; lo_wr_data = 8'h02; step();
      chk("R10", pc, 13'h1502);

      // R7: return keeps latch
      ret_en = 1; ret_val = 13'h0042; step();
      goto_en = 1; jmp_tgt = 11'h000; step();
      chk("R7", pc, 13'h1000);

      // R8: all at once, low-byte write wins; then return beats jump
      lo_wr_en = 1; ret_en = 1; goto_en = 1; inc_en = 1; lo_wr_data = 8'hEE;
      ret_val = 13'h0333; jmp_tgt = 11'h444; step();
      chk("R8", pc, 13'h15EE);
      ret_en = 1; call_en = 1; inc_en = 1; ret_val = 13'h0999; step();
      chk("R8", pc, 13'h0999);

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         inc_en      = (r < 60);
         goto_en     = ($urandom_range(0, 9) == 0);
         call_en     = ($urandom_range(0, 9) == 0);
         ret_en      = ($urandom_range(0, 14) == 0);
         lo_wr_en    = ($urandom_range(0, 14) == 0);
         lat_wr_en   = ($urandom_range(0, 7) == 0);
         jmp_tgt     = 11'($urandom);
         ret_val     = ($urandom_range(0, 7) == 0) ? 13'h1FFF : 13'($urandom);
         lo_wr_data  = 8'($urandom);
         lat_wr_data = 5'($urandom);
         step();
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule